// File: doc/BRIEF.md
# Packet Stream Halfword Narrower

This block takes a packetized stream of 36-bit words and emits a packetized stream of 19-bit words. Each wide word holds 32 data bits, a start marker, an end marker and a 2-bit field giving how many bytes of the last word are valid. The narrow side carries 16 data bits, the two markers and one bit that flags a final halfword holding a single byte. Each wide word becomes one or two halfwords, upper half first. An upper half that already holds every valid byte ends the packet on its own.

Both sides use a ready/ready handshake. A word crosses only in a cycle where the sending side's source-ready and the receiving side's destination-ready are both high. The block holds a single wide word and hands out its halves. It takes the next wide word in the same cycle that the last half of the current one is accepted, so a steady stream flows without idle cycles.

Top module: `pkt_narrow_36to19`

## Requirements
- R1: A wide word is captured only in a cycle with both `in_src_rdy` and `in_dst_rdy` high. The wide word is packed as occupancy in bits 35:34, end marker in bit 33, start marker in bit 32 and data in bits 31:0.
- R2: Reset is synchronous and active low. While the block is empty after reset, `out_src_rdy` is low and `in_dst_rdy` is high.
- R3: The narrow word is packed as half-full flag in bit 18, end marker in bit 17, start marker in bit 16 and data in bits 15:0. Data bits 31:16 go out first and bits 15:0 second.
- R4: The start marker appears only on the first halfword produced from a word that carries it.
- R5: An end word with occupancy 01 (one byte) yields one halfword, carrying the end marker and a half-full flag of 1.
- R6: An end word with occupancy 10 (two bytes) yields one halfword, carrying the end marker and a half-full flag of 0.
- R7: An end word with occupancy 11 (three bytes) yields two halfwords. Only the second carries the end marker, and it has a half-full flag of 1.
- R8: An end word with occupancy 00 (four bytes) yields two halfwords. Only the second carries the end marker, and its half-full flag is 0.
- R9: A word with both start and end markers set is treated as four full bytes, whatever its occupancy bits hold. It yields two halfwords, the end marker on the second and a half-full flag of 0.
- R10: A word without the end marker yields two halfwords, with no end marker and a half-full flag of 0, whatever its occupancy bits hold.
- R11: `in_dst_rdy` is high only when the block is empty or when the final halfword of the held word is being accepted. While `out_dst_rdy` is low, the offered halfword stays valid and unchanged.
- R12: A new wide word offered in the cycle the final halfword leaves is captured, and its first halfword is offered in the next cycle with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 36 | Wide word: occupancy, end, start, data |
| in_src_rdy | input | 1 | Upstream offers a wide word |
| in_dst_rdy | output | 1 | Block can take a wide word |
| out_data | output | 19 | Narrow word: half-full, end, start, data |
| out_src_rdy | output | 1 | Block offers a halfword |
| out_dst_rdy | input | 1 | Downstream can take a halfword |

## Verification
Two functions can fall in the same cycle: the last halfword of one word leaving downstream, and the next wide word being captured. The bench provokes this by holding a one-halfword end word and then a two-halfword start word at the input with the output always ready. It judges the overlap by requiring `in_dst_rdy` high in the draining cycle and the new word's upper half on the very next cycle. Stalls are judged separately: the first half of a held word must stay frozen while the downstream side is not ready.

// File: rtl/pkt_narrow_pkg.sv
// Shared types and decode helpers for the wide-to-narrow packet converter.
// Assumes a 2-bit byte-count occupancy field on the wide side.
package pkt_narrow_pkg;

    // Control flags that travel with a wide word
    typedef struct packed {
        logic [1:0] occ;
        logic       eop;
        logic       sop;
    } pn_flags_t;

    // True when a held word is fully described by its upper halfword
    function automatic logic pn_single_half(input pn_flags_t f);
        return f.eop && !f.sop && (f.occ == 2'b01 || f.occ == 2'b10);
    endfunction

    // True when the final halfword of the word holds only one byte
    function automatic logic pn_short_tail(input pn_flags_t f);
        return f.eop && !f.sop && f.occ[0];
    endfunction

endpackage

// File: rtl/pn_hold_reg.sv
// Holding register for one wide word plus a halfword phase bit.
// Runs the input handshake and steps through halves as downstream accepts.
// Assumes the synchronous active-low reset; data registers are not reset.
module pn_hold_reg
    import pkt_narrow_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pn_flags_t         in_flags,
    input  logic [DATA_W-1:0] in_word,
    input  logic              in_src_rdy,
    output logic              in_dst_rdy,
    input  logic              out_dst_rdy,
    output logic              held_valid,
    output logic              held_phase,
    output logic              held_last,
    output pn_flags_t         held_flags,
    output logic [DATA_W-1:0] held_word
);

    logic load;

    // Current half is the final one of the held word
    always_comb held_last = held_phase || pn_single_half(held_flags);

    // Input handshake: free when empty or when the final half is leaving
    always_comb in_dst_rdy = !held_valid || (out_dst_rdy && held_last);

    // A wide word is captured on a completed input transfer
    always_comb load = in_src_rdy && in_dst_rdy;

    // Occupancy and phase state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_valid <= 1'b0;
            held_phase <= 1'b0;
        end else if (load) begin
            held_valid <= 1'b1;
            held_phase <= 1'b0;
        end else if (held_valid && out_dst_rdy) begin
            if (held_last) held_valid <= 1'b0;
            else           held_phase <= 1'b1;
        end
    end

    // Payload capture on load
    always_ff @(posedge clk) begin
        if (load) begin
            held_flags <= in_flags;
            held_word  <= in_word;
        end
    end

endmodule

// File: rtl/pn_half_select.sv
// Builds the narrow output word from the held wide word and the phase.
// Picks the upper half in phase 0 and the lower in phase 1, and rewrites
// the markers and occupancy. Purely combinational.
module pn_half_select
    import pkt_narrow_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              held_valid,
    input  logic              held_phase,
    input  logic              held_last,
    input  pn_flags_t         held_flags,
    input  logic [DATA_W-1:0] held_word,
    output logic              out_src_rdy,
    output logic              half_occ,
    output logic              half_eop,
    output logic              half_sop,
    output logic [HALF_W-1:0] half_data
);

    logic [HALF_W-1:0] halves [2];

    // Split the wide word into its two halfwords, upper first
    for (genvar g = 0; g < 2; g++) begin : g_split
        assign halves[g] = held_word[DATA_W-1-g*HALF_W -: HALF_W];
    end

    // Output valid mirrors the holding register
    always_comb out_src_rdy = held_valid;

    // Marker and occupancy rewrite for the current halfword
    always_comb begin
        half_data = halves[held_phase];
        half_sop  = held_flags.sop && !held_phase;
        half_eop  = held_flags.eop && held_last;
        half_occ  = held_last && pn_short_tail(held_flags);
    end

endmodule

// File: rtl/pkt_narrow_36to19.sv
// Top level: wide packet stream in, halfword packet stream out.
// Holds one wide word; emits one or two halfwords per word.
// Assumes a synchronous active-low reset and ready/ready handshakes.
module pkt_narrow_36to19
    import pkt_narrow_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2,
    localparam int IN_W   = DATA_W + 4,
    localparam int OUT_W  = HALF_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_src_rdy,
    output logic             in_dst_rdy,
    output logic [OUT_W-1:0] out_data,
    output logic             out_src_rdy,
    input  logic             out_dst_rdy
);

    pn_flags_t         in_flags;
    pn_flags_t         held_flags;
    logic [DATA_W-1:0] held_word;
    logic              held_valid;
    logic              held_phase;
    logic              held_last;
    logic              half_occ;
    logic              half_eop;
    logic              half_sop;
    logic [HALF_W-1:0] half_data;

    // Unpack the wide word's flag field
    always_comb in_flags = pn_flags_t'(in_data[IN_W-1:DATA_W]);

    pn_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_flags    (in_flags),
        .in_word     (in_data[DATA_W-1:0]),
        .in_src_rdy  (in_src_rdy),
        .in_dst_rdy  (in_dst_rdy),
        .out_dst_rdy (out_dst_rdy),
        .held_valid  (held_valid),
        .held_phase  (held_phase),
        .held_last   (held_last),
        .held_flags  (held_flags),
        .held_word   (held_word)
    );

    pn_half_select #(.DATA_W(DATA_W)) u_sel (
        .held_valid  (held_valid),
        .held_phase  (held_phase),
        .held_last   (held_last),
        .held_flags  (held_flags),
        .held_word   (held_word),
        .out_src_rdy (out_src_rdy),
        .half_occ    (half_occ),
        .half_eop    (half_eop),
        .half_sop    (half_sop),
        .half_data   (half_data)
    );

    // Pack the narrow word: half-full, end, start, data
    always_comb out_data = {half_occ, half_eop, half_sop, half_data};

endmodule

// File: rtl/pkt_narrow_chk.sv
// Assertion checker for pkt_narrow_36to19, attached through bind.
module pkt_narrow_chk #(
    parameter int IN_W  = 36,
    parameter int OUT_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  in_data,
    input logic             in_src_rdy,
    input logic             in_dst_rdy,
    input logic [OUT_W-1:0] out_data,
    input logic             out_src_rdy,
    input logic             out_dst_rdy
);
    localparam int OCC_B = OUT_W - 1;
    localparam int EOP_B = OUT_W - 2;
    localparam int SOP_B = OUT_W - 3;

    // R1: a captured word is offered on the next cycle
    p_capture_offers_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_src_rdy && in_dst_rdy |=> out_src_rdy);

    // R11: a stalled halfword stays valid and unchanged
    p_stall_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_src_rdy && !out_dst_rdy |=> out_src_rdy && $stable(out_data));

    // R11: input ready only when empty or downstream is taking a half
    p_ready_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_dst_rdy |-> (!out_src_rdy || out_dst_rdy));

    // R4: after a start-marked half that is not the end, the next half has no start
    p_sop_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_src_rdy && out_dst_rdy && out_data[SOP_B] && !out_data[EOP_B]
        |=> out_src_rdy && !out_data[SOP_B]);

    // R5: the half-full flag only ever appears on an end halfword
    p_occ_needs_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_src_rdy |-> !(out_data[OCC_B] && !out_data[EOP_B]));

endmodule

bind pkt_narrow_36to19 pkt_narrow_chk #(.IN_W(36), .OUT_W(19)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_data     (in_data),
    .in_src_rdy  (in_src_rdy),
    .in_dst_rdy  (in_dst_rdy),
    .out_data    (out_data),
    .out_src_rdy (out_src_rdy),
    .out_dst_rdy (out_dst_rdy)
);

// File: tb/tb_pkt_narrow_36to19.sv
`timescale 1ns/1ps
module tb_pkt_narrow_36to19;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [35:0] in_data;
    logic        in_src_rdy;
    logic        in_dst_rdy;
    logic [18:0] out_data;
    logic        out_src_rdy;
    logic        out_dst_rdy;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    pkt_narrow_36to19 dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_src_rdy  (in_src_rdy),
        .in_dst_rdy  (in_dst_rdy),
        .out_data    (out_data),
        .out_src_rdy (out_src_rdy),
        .out_dst_rdy (out_dst_rdy)
    );

    localparam logic [31:0] D = 32'hA1B2_C3D4;
    localparam logic [15:0] HI = 16'hA1B2;
    localparam logic [15:0] LO = 16'hC3D4;

    // Vector: {req tag, wide word, halfword count, first half, second half}
    // Wide word = {occ[1:0], eop, sop, data}; narrow = {occ, eop, sop, data16}
    localparam int NV = 8;
    localparam logic [79:0] VEC [NV] = '{
        {4'd10, 2'b01, 1'b0, 1'b0, D, 2'd2, 3'b000, HI, 3'b000, LO}, // R10 mid word, occ ignored
        {4'd4,  2'b00, 1'b0, 1'b1, D, 2'd2, 3'b001, HI, 3'b000, LO}, // R4 / R3 start word
        {4'd5,  2'b01, 1'b1, 1'b0, D, 2'd1, 3'b110, HI, 3'b000, 16'h0}, // R5 one byte
        {4'd6,  2'b10, 1'b1, 1'b0, D, 2'd1, 3'b010, HI, 3'b000, 16'h0}, // R6 two bytes
        {4'd7,  2'b11, 1'b1, 1'b0, D, 2'd2, 3'b000, HI, 3'b110, LO}, // R7 three bytes
        {4'd8,  2'b00, 1'b1, 1'b0, D, 2'd2, 3'b000, HI, 3'b010, LO}, // R8 four bytes
        {4'd9,  2'b11, 1'b1, 1'b1, D, 2'd2, 3'b001, HI, 3'b010, LO}, // R9 start+end, error bits
        {4'd9,  2'b01, 1'b1, 1'b1, D, 2'd2, 3'b001, HI, 3'b010, LO}  // R9 start+end, error bits
    };

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_src_rdy = 1'b0; out_dst_rdy = 1'b1; in_data = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL all watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_src_rdy = 1'b0; out_dst_rdy = 1'b1; in_data = '0;
        do_reset();

        // R2: empty after reset
        @(negedge clk);
        check("R2 out_src_rdy after reset", {35'd0, out_src_rdy}, 36'd0);
        check("R2 in_dst_rdy after reset", {35'd0, in_dst_rdy}, 36'd1);

        // R1: no capture while in_src_rdy is low
        in_data = {2'b00, 1'b0, 1'b1, D};
        repeat (3) @(negedge clk);
        check("R1 no capture without src ready", {35'd0, out_src_rdy}, 36'd0);

        // Table walk with downstream always ready
        for (int v = 0; v < NV; v++) begin
            logic [3:0]  tag;
            logic [35:0] w;
            logic [1:0]  n;
            logic [18:0] e [2];
            {tag, w, n, e[0], e[1]} = VEC[v];
            @(negedge clk);
            in_data = w; in_src_rdy = 1'b1; out_dst_rdy = 1'b1;
            while (!in_dst_rdy) @(negedge clk);
            @(negedge clk);
            in_src_rdy = 1'b0;
            for (int h = 0; h < int'(n); h++) begin
                check($sformatf("R%0d half %0d valid", tag, h), {35'd0, out_src_rdy}, 36'd1);
                check($sformatf("R%0d half %0d word", tag, h), {17'd0, out_data}, {17'd0, e[h]});
                @(negedge clk);
            end
            check($sformatf("R%0d no extra half", tag), {35'd0, out_src_rdy}, 36'd0);
        end

        // R11: backpressure holds the first half and blocks input
        @(negedge clk);
        out_dst_rdy = 1'b0;
        in_data = {2'b00, 1'b0, 1'b0, D}; in_src_rdy = 1'b1;
        @(negedge clk);
        in_src_rdy = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R11 stalled half stays", {16'd0, out_src_rdy, out_data}, {16'd0, 1'b1, 3'b000, HI});
            check("R11 input blocked while stalled", {35'd0, in_dst_rdy}, 36'd0);
        end
        out_dst_rdy = 1'b1;
        #0.1;
        check("R11 not ready on first half", {35'd0, in_dst_rdy}, 36'd0);
        @(negedge clk);
        check("R11 ready on final half", {35'd0, in_dst_rdy}, 36'd1);
        check("R3 lower half after stall", {17'd0, out_data}, {17'd0, 3'b000, LO});
        @(negedge clk);

        // R12: back-to-back words, no bubble
        in_data = {2'b01, 1'b1, 1'b0, D}; in_src_rdy = 1'b1; out_dst_rdy = 1'b1;
        @(negedge clk);
        in_data = {2'b00, 1'b0, 1'b1, 32'h5566_7788};
        check("R12 one-byte end half offered", {17'd0, out_data}, {17'd0, 3'b110, HI});
        check("R12 ready while final half leaves", {35'd0, in_dst_rdy}, 36'd1);
        @(negedge clk);
        in_src_rdy = 1'b0;
        check("R12 next word without gap", {16'd0, out_src_rdy, out_data}, {16'd0, 1'b1, 3'b001, 16'h5566});
        @(negedge clk);
        check("R12 next word lower half", {17'd0, out_data}, {17'd0, 3'b000, 16'h7788});
        @(negedge clk);
        check("R12 drained", {35'd0, out_src_rdy}, 36'd0);

        // R2: reset while holding a word empties the block
        out_dst_rdy = 1'b0;
        in_data = {2'b00, 1'b0, 1'b0, D}; in_src_rdy = 1'b1;
        @(negedge clk);
        in_src_rdy = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 reset clears held word", {35'd0, out_src_rdy}, 36'd0);
        check("R2 reset frees input", {35'd0, in_dst_rdy}, 36'd1);
        rst_n = 1'b1;
        out_dst_rdy = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule